// File: doc/BRIEF.md
# Luminance Peaking and Coring Path

This block takes an 8-bit luminance stream, one sample per `in_vld` strobe, and returns a processed stream with its own strobe. The main path goes through a chroma notch that removes the colour subcarrier. The notch can be tuned for a 4.43 MHz or a 3.58 MHz carrier, or it can be bypassed when the luminance comes from a separated (S-Video) source. A gain stage after the notch scales the result so that a flat input leaves the block at the same level in every notch mode.

A second branch takes high-frequency detail from a five-sample window, using one of two bandpass shapes. When coring is on, detail of magnitude one LSB or less is set to zero. The detail is then added to the main path and the sum is clamped to 0..255. The block holds all samples in one shared window and centres every branch on the same sample, so the branches need no separate delay lines. The configuration pins are captured together with each accepted sample, so a change on them only affects samples accepted after it.

Top module: `luma_peak_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first output, `y_out` is 0 and `out_vld` is 0. Reset clears the sample window to zeros and discards any samples still in flight.
- R2: Each cycle with `in_vld` high produces exactly one cycle with `out_vld` high, three clock edges later. `y_out` holds its value in cycles where `out_vld` is low.
- R3: Let x[k] be the newest accepted sample and x[k-1]..x[k-4] the four before it, with zeros before reset. The output for x[k] is centred on x[k-2] and uses the configuration pins sampled with x[k].
- R4: With `notch_byp`=0 and `notch_sel`=0 (4.43 MHz), main = floor((x[k-1]+x[k-2]+x[k-3])*171/512), limited to 255.
- R5: With `notch_byp`=0 and `notch_sel`=1 (3.58 MHz), main = floor((x[k-1]+x[k-3])/2).
- R6: With `notch_byp`=1, main = x[k-2], whatever the value of `notch_sel`.
- R7: A constant input c gives main = c in both notch modes and in bypass (equal DC gain).
- R8: Detail is floor((2*x[k-2]-x[k-1]-x[k-3])/4) when `peak_sel`=0, and floor((2*x[k-2]-x[k]-x[k-4])/4) when `peak_sel`=1.
- R9: With `core_en`=1, a detail value of -1, 0 or +1 becomes 0. With `core_en`=0, the detail is used unchanged.
- R10: With `peak_en`=1, y_out = main + detail. With `peak_en`=0, y_out = main and the detail has no effect.
- R11: The sum main + detail is clamped to the range 0..255 and never wraps.
- R12: Configuration pins that change while `in_vld` is low do not alter outputs for samples that were already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe; captures y_in and configuration |
| y_in | input | 8 | Input luminance sample |
| notch_sel | input | 1 | Notch carrier: 0 = 4.43 MHz, 1 = 3.58 MHz |
| notch_byp | input | 1 | 1 = bypass the notch (separated luminance) |
| peak_sel | input | 1 | Bandpass shape: 0 = narrow taps, 1 = wide taps |
| peak_en | input | 1 | 1 = add detail to the main path |
| core_en | input | 1 | 1 = zero detail within one LSB |
| out_vld | output | 1 | Output sample strobe |
| y_out | output | 8 | Processed luminance |

## Verification
Coring and saturation both act on the same output sample. The bench therefore drives edges where the detail is large, which triggers the clamp at 0 and at 255, and small alternations where the detail is exactly one LSB, which triggers coring. For every output, the result is compared with values derived from the requirement formulas. A configuration change can also fall in the same cycle as a sample already moving through the pipeline. This case is provoked by changing the pins in the idle cycle right after a sample is accepted, and the check confirms that output still follows the configuration captured with that sample.

// File: rtl/luma_pkg.sv
package luma_pkg;

    typedef struct packed {
        logic notch_sel;
        logic notch_byp;
        logic peak_sel;
        logic peak_en;
        logic core_en;
    } luma_cfg_t;

endpackage

// File: rtl/luma_tap_line.sv
module luma_tap_line
    import luma_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NTAP = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [DW-1:0]             y_in,
    input  luma_cfg_t                 cfg_in,
    output logic [NTAP-1:0][DW-1:0]   win_out,
    output luma_cfg_t                 cfg_out,
    output logic                      vld_out
);

    typedef struct packed {
        logic [NTAP-1:0][DW-1:0] win;
        luma_cfg_t               cfg;
        logic                    vld;
    } tap_st_t;

    tap_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.win[0] = y_in;
            for (int i = 1; i < NTAP; i++) begin
                st_d.win[i] = st_q.win[i-1];
            end
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_out = st_q.win;
    assign cfg_out = st_q.cfg;
    assign vld_out = st_q.vld;

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(cfg_out));

    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(win_out));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> vld_out);

endmodule

// File: rtl/luma_notch.sv
module luma_notch #(
    parameter int DW        = 8,
    parameter int GAIN_MUL  = 171,
    parameter int GAIN_SHR  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_in,
    input  logic [DW-1:0] w1,
    input  logic [DW-1:0] w2,
    input  logic [DW-1:0] w3,
    input  logic          notch_sel,
    input  logic          notch_byp,
    input  logic          peak_en_in,
    output logic [DW-1:0] main_out,
    output logic          peak_en_out,
    output logic          vld_out
);

    localparam int SW3 = DW + 2;
    localparam int SW2 = DW + 1;
    localparam int MW  = SW3 + $clog2(GAIN_MUL + 1);
    localparam logic [DW-1:0] MAXV = '1;

    typedef struct packed {
        logic [DW-1:0] main;
        logic          peak_en;
        logic          vld;
    } notch_st_t;

    notch_st_t st_d, st_q;

    logic [SW3-1:0] sum3;
    logic [SW2-1:0] sum2;
    logic [MW-1:0]  prod;
    logic [MW-1:0]  scaled;
    logic [DW-1:0]  wide_main;
    logic [DW-1:0]  narrow_main;

    always_comb begin
        sum3   = SW3'(w1) + SW3'(w2) + SW3'(w3);
        sum2   = SW2'(w1) + SW2'(w3);
        prod   = MW'(sum3) * MW'(GAIN_MUL);
        scaled = prod >> GAIN_SHR;
        if (scaled > MW'(MAXV)) wide_main = MAXV;
        else                    wide_main = scaled[DW-1:0];
        narrow_main = sum2[DW:1];

        st_d     = st_q;
        st_d.vld = vld_in;
        if (vld_in) begin
            st_d.peak_en = peak_en_in;
            if (notch_byp)      st_d.main = w2;
            else if (notch_sel) st_d.main = narrow_main;
            else                st_d.main = wide_main;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_out    = st_q.main;
    assign peak_en_out = st_q.peak_en;
    assign vld_out     = st_q.vld;

    // R6
    byp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && notch_byp) |=> (main_out == $past(w2)));

    // R7
    dc_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && (w1 == w2) && (w2 == w3)) |=> (main_out == $past(w2)));

endmodule

// File: rtl/luma_peak.sv
module luma_peak #(
    parameter int DW      = 8,
    parameter int NTAP    = 5,
    parameter int CORE_TH = 1,
    localparam int SW     = DW + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_in,
    input  logic [NTAP-1:0][DW-1:0] win,
    input  logic                    peak_sel,
    input  logic                    core_en,
    output logic signed [SW-1:0]    detail_out
);

    localparam int CTR = NTAP / 2;

    typedef struct packed {
        logic signed [SW-1:0] detail;
    } peak_st_t;

    peak_st_t st_d, st_q;

    logic [DW-1:0]        tap_a;
    logic [DW-1:0]        tap_b;
    logic [SW-1:0]        centre2;
    logic [SW-1:0]        edge_sum;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] raw;
    logic                 in_band;

    always_comb begin
        if (peak_sel) begin
            tap_a = win[0];
            tap_b = win[NTAP-1];
        end else begin
            tap_a = win[CTR-1];
            tap_b = win[CTR+1];
        end
        centre2  = SW'(win[CTR]) << 1;
        edge_sum = SW'(tap_a) + SW'(tap_b);
        diff     = $signed(centre2 - edge_sum);
        raw      = diff >>> 2;
        in_band  = (raw >= -CORE_TH) && (raw <= CORE_TH);

        st_d = st_q;
        if (vld_in) begin
            if (core_en && in_band) st_d.detail = '0;
            else                    st_d.detail = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign detail_out = st_q.detail;

    // R9
    core_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && core_en) |=>
        ((detail_out == 0) || (detail_out > CORE_TH) || (detail_out < -CORE_TH)));

endmodule

// File: rtl/luma_peak_core.sv
module luma_peak_core
    import luma_pkg::*;
#(
    parameter int DW       = 8,
    parameter int GAIN_MUL = 171,
    parameter int GAIN_SHR = 9,
    parameter int CORE_TH  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] y_in,
    input  logic          notch_sel,
    input  logic          notch_byp,
    input  logic          peak_sel,
    input  logic          peak_en,
    input  logic          core_en,
    output logic          out_vld,
    output logic [DW-1:0] y_out
);

    localparam int NTAP = 5;
    localparam int CTR  = NTAP / 2;
    localparam int SW   = DW + 3;
    localparam int SUMW = SW + 1;
    localparam int MAXI = (1 << DW) - 1;

    luma_cfg_t               cfg_pins;
    luma_cfg_t               cfg1;
    logic [NTAP-1:0][DW-1:0] win1;
    logic                    vld1;
    logic [DW-1:0]           main2;
    logic                    peak_en2;
    logic                    vld2;
    logic signed [SW-1:0]    detail2;

    always_comb begin
        cfg_pins.notch_sel = notch_sel;
        cfg_pins.notch_byp = notch_byp;
        cfg_pins.peak_sel  = peak_sel;
        cfg_pins.peak_en   = peak_en;
        cfg_pins.core_en   = core_en;
    end

    luma_tap_line #(.DW(DW), .NTAP(NTAP)) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .y_in    (y_in),
        .cfg_in  (cfg_pins),
        .win_out (win1),
        .cfg_out (cfg1),
        .vld_out (vld1)
    );

    luma_notch #(.DW(DW), .GAIN_MUL(GAIN_MUL), .GAIN_SHR(GAIN_SHR)) u_notch (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_in      (vld1),
        .w1          (win1[CTR-1]),
        .w2          (win1[CTR]),
        .w3          (win1[CTR+1]),
        .notch_sel   (cfg1.notch_sel),
        .notch_byp   (cfg1.notch_byp),
        .peak_en_in  (cfg1.peak_en),
        .main_out    (main2),
        .peak_en_out (peak_en2),
        .vld_out     (vld2)
    );

    luma_peak #(.DW(DW), .NTAP(NTAP), .CORE_TH(CORE_TH)) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_in     (vld1),
        .win        (win1),
        .peak_sel   (cfg1.peak_sel),
        .core_en    (cfg1.core_en),
        .detail_out (detail2)
    );

    typedef struct packed {
        logic [DW-1:0] y;
        logic          vld;
    } out_st_t;

    out_st_t st_d, st_q;

    logic signed [SUMW-1:0] sum;

    always_comb begin
        sum = $signed({{(SUMW-DW){1'b0}}, main2}) + $signed({detail2[SW-1], detail2});

        st_d     = st_q;
        st_d.vld = vld2;
        if (vld2) begin
            if (!peak_en2)      st_d.y = main2;
            else if (sum < 0)   st_d.y = '0;
            else if (sum > MAXI) st_d.y = DW'(MAXI);
            else                st_d.y = sum[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_out   = st_q.y;
    assign out_vld = st_q.vld;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 3));

    // R10
    peak_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld2 && !peak_en2) |=> (y_out == $past(main2)));

    // R11
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld2 && peak_en2 && (detail2 > 0)) |=> (y_out >= $past(main2)));

    // R11
    no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld2 && peak_en2 && (detail2 < 0)) |=> (y_out <= $past(main2)));

endmodule

// File: tb/luma_peak_core_tb.sv
module luma_peak_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] y_in = '0;
    logic       notch_sel = 1'b0;
    logic       notch_byp = 1'b0;
    logic       peak_sel = 1'b0;
    logic       peak_en = 1'b0;
    logic       core_en = 1'b0;
    logic       out_vld;
    logic [7:0] y_out;

    always #2 clk = ~clk;

    luma_peak_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .y_in      (y_in),
        .notch_sel (notch_sel),
        .notch_byp (notch_byp),
        .peak_sel  (peak_sel),
        .peak_en   (peak_en),
        .core_en   (core_en),
        .out_vld   (out_vld),
        .y_out     (y_out)
    );

    int checks = 0;
    int errors = 0;
    int hist [5];
    logic [7:0] fexp [$];
    string      ftag [$];
    logic [2:0] vh = '0;
    logic [7:0] last_y = '0;

    // cfg bits: {core_en, peak_en, peak_sel, notch_byp, notch_sel}
    localparam int NV = 24;
    localparam logic [12:0] VEC [NV] = '{
        {5'b00000, 8'd10},  {5'b00000, 8'd200}, {5'b00000, 8'd30},  {5'b00000, 8'd120},
        {5'b00001, 8'd250}, {5'b00001, 8'd5},   {5'b00001, 8'd90},  {5'b00001, 8'd170},
        {5'b00010, 8'd60},  {5'b00011, 8'd220}, {5'b00010, 8'd15},  {5'b01000, 8'd140},
        {5'b01000, 8'd80},  {5'b01100, 8'd210}, {5'b01100, 8'd40},  {5'b01010, 8'd255},
        {5'b01110, 8'd0},   {5'b11000, 8'd101}, {5'b11000, 8'd99},  {5'b11100, 8'd100},
        {5'b11010, 8'd180}, {5'b11110, 8'd20},  {5'b01001, 8'd230}, {5'b11101, 8'd7}
    };

    function automatic int model(input logic [4:0] c, output string tg);
        int m, d;
        if (c[1])      m = hist[2];
        else if (c[0]) m = (hist[1] + hist[3]) / 2;
        else           m = ((hist[1] + hist[2] + hist[3]) * 171) / 512;
        if (m > 255) m = 255;
        if (c[2]) d = (2*hist[2] - hist[0] - hist[4]) >>> 2;
        else      d = (2*hist[2] - hist[1] - hist[3]) >>> 2;
        tg = c[1] ? "R6" : (c[0] ? "R5" : "R4");
        if (c[3]) begin
            tg = "R8 R10";
            if (c[4] && d >= -1 && d <= 1) begin
                if (d != 0) tg = "R9";
                d = 0;
            end
            m = m + d;
            if (m > 255) begin m = 255; tg = "R11"; end
            if (m < 0)   begin m = 0;   tg = "R11"; end
        end
        return m;
    endfunction

    task automatic push(input logic [7:0] s, input logic [4:0] c, input string tg);
        string mt;
        int e;
        @(posedge clk); #1;
        y_in = s; in_vld = 1'b1;
        {core_en, peak_en, peak_sel, notch_byp, notch_sel} = c;
        for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        e = model(c, mt);
        fexp.push_back(8'(e));
        ftag.push_back(tg == "" ? mt : tg);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_vld = 1'b0;
        end
    endtask

    task automatic check(input string tg, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tg, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            vh <= '0;
            last_y <= '0;
        end else begin
            if (vh[2] || out_vld) check("R2 latency", out_vld, vh[2]);
            if (out_vld) begin
                if (fexp.size() == 0) check("R2 extra output", 1, 0);
                else check(ftag.pop_front(), y_out, fexp.pop_front());
                last_y <= y_out;
            end else if (y_out != last_y) begin
                check("R2 hold", y_out, last_y);
            end
            vh <= {vh[1:0], in_vld};
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) hist[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset y_out", y_out, 0);
        check("R1 reset out_vld", out_vld, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release y_out", y_out, 0);

        for (int v = 0; v < NV; v++) push(VEC[v][7:0], VEC[v][12:8], "");
        idle(6);

        // R3 impulse with bypass, wide bandpass
        for (int i = 0; i < 9; i++) push(i == 4 ? 8'd200 : 8'd0, 5'b01110, "R3");
        idle(6);

        // R7 flat input in each notch mode
        for (int i = 0; i < 6; i++) push(8'd100, 5'b00000, "R7");
        for (int i = 0; i < 6; i++) push(8'd100, 5'b00001, "R7");
        for (int i = 0; i < 6; i++) push(8'd213, 5'b00000, "R7");
        idle(6);

        // R11 full-scale alternation clamps both ways
        for (int i = 0; i < 8; i++) push(i[0] ? 8'd255 : 8'd0, 5'b01010, "R11");
        idle(6);

        // R9 one-LSB detail cored, then not cored
        for (int i = 0; i < 8; i++) push(i[0] ? 8'd102 : 8'd100, 5'b11010, "R9");
        for (int i = 0; i < 8; i++) push(i[0] ? 8'd102 : 8'd100, 5'b01010, "R9");
        idle(6);

        // R12 configuration flips in gap while sample in flight
        push(8'd40, 5'b00010, "R12");
        push(8'd230, 5'b00010, "R12");
        push(8'd60, 5'b00010, "R12");
        @(posedge clk); #1;
        in_vld = 1'b0;
        {core_en, peak_en, peak_sel, notch_byp, notch_sel} = 5'b01101;
        idle(6);

        // R2 sparse strobes
        for (int i = 0; i < 6; i++) begin
            push(8'(37 * i + 11), 5'b01000, "R2");
            idle(i % 3 + 1);
        end
        idle(6);
        check("R2 all outputs seen", fexp.size(), 0);

        // R1 reset flushes in-flight samples
        push(8'd77, 5'b00000, "R1");
        push(8'd88, 5'b00000, "R1");
        @(posedge clk); #1;
        in_vld = 1'b0;
        rst_n = 1'b0;
        fexp.delete();
        ftag.delete();
        for (int i = 0; i < 5; i++) hist[i] = 0;
        #1;
        check("R1 mid reset out_vld", out_vld, 0);
        check("R1 mid reset y_out", y_out, 0);
        idle(2);
        rst_n = 1'b1;
        idle(6);
        check("R1 flushed y_out", y_out, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule